// File: doc/BRIEF.md
# Pipelined register-access port with write stall

This block is a small bank of read/write registers reached through a strobe-based CPU request port. The requester raises a one-cycle request strobe together with a write flag, a word address and, for writes, the write data. Reads and writes answer on separate acknowledge outputs. Each acknowledge comes with an error flag, and read acknowledges also carry the read data. All response fields are meaningful only in the cycle the matching acknowledge is high.

Writes always complete in the cycle they are presented. Reads complete after a fixed, parameterised latency of 0 to 3 cycles, and a new request may be issued every cycle. A write acknowledge must never overtake an older read, so the block raises a write-stall output while any read is in flight. A write presented during the stall is not taken: no register changes and no acknowledge is given. The requester keeps presenting the write until the stall drops. Addresses at or above the register count are unmapped and complete with the error flag set.

Top module: `cpu_reg_port`

## Requirements
- R1: While reset is held and just after it is released, every register reads zero and `wr_ack`, `rd_ack` and `wr_stall` are low.
- R2: A write to a mapped address (`addr` < NUM_REGS) presented while `wr_stall` is low is acknowledged in the same cycle with `wr_err`=0. Later reads of that address return the written data.
- R3: A read request is acknowledged exactly RD_LAT cycles after the cycle it is presented, and the same cycle when RD_LAT=0. For a mapped address, `rd_err`=0 and `rd_data` equals the register's contents at the time of the request.
- R4: An access to an unmapped address (`addr` >= NUM_REGS) completes with its error flag set to 1. An unmapped write changes no register, and an unmapped read returns all-zero data.
- R5: Reads issued in consecutive cycles are acknowledged in consecutive cycles, in request order.
- R6: `wr_stall` is high from the cycle after a read is taken up to and including the cycle of its acknowledge. Otherwise it is low.
- R7: A write presented while `wr_stall` is high gets no acknowledge and changes no register. The same write presented again after the stall drops is accepted.
- R8: `rd_ack` and `wr_ack` are never high in the same cycle. Acknowledges leave in request order.
- R9: No acknowledge is produced in a cycle that carries no matching request, apart from a read answered after its latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle request strobe |
| req_wr | input | 1 | 1 = write, 0 = read; valid with `req` |
| addr | input | ADDR_W | Register word address; valid with `req` |
| wdata | input | DATA_W | Write data; valid with a write request |
| wr_stall | output | 1 | High while reads are outstanding; writes are not taken |
| wr_ack | output | 1 | Write completion pulse |
| wr_err | output | 1 | Write error, valid with `wr_ack` |
| rd_ack | output | 1 | Read completion pulse |
| rd_err | output | 1 | Read error, valid with `rd_ack` |
| rd_data | output | DATA_W | Read data, valid with `rd_ack` |

## Verification
The bench targets the boundary between a write and the read just ahead of it. A design whose stall dropped one cycle early would acknowledge that write in the same cycle as the read, or ahead of it. Back-to-back read bursts expose a pipeline that loses or repeats a stage, which would show up as a missing or doubled acknowledge or as data from the wrong address. Unmapped addresses on both edges of the map show whether an error write leaks into a register or an error read returns stale data. Writes dropped during a stall, followed by a read-back, show whether a stalled write still touched the bank.

// File: rtl/cpu_reg_port_pkg.sv
package cpu_reg_port_pkg;

    // Upper bound on the read response delay the pipe supports.
    localparam int unsigned MAX_RD_LAT = 3;

    // True when a word address falls inside the implemented bank.
    function automatic logic addr_mapped(input logic [31:0] a, input int unsigned n);
        return a < n;
    endfunction

endpackage

// File: rtl/cpu_reg_port_bank.sv
module cpu_reg_port_bank
    import cpu_reg_port_pkg::*;
#(
    parameter int unsigned NUM_REGS = 10,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        hit   = addr_mapped(32'(addr), NUM_REGS);
        st_d  = st_q;
        rdata = '0;
        for (int i = 0; i < int'(NUM_REGS); i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = st_q.regs[i];
                if (wr_en) st_d.regs[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Unmapped writes leave the whole bank untouched.
    p_unmapped_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(st_q));

    // A mapped write is visible at the same address in the next cycle.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) ##1 (addr == $past(addr)) |-> (rdata == $past(wdata)));

endmodule

// File: rtl/cpu_reg_port_rdpipe.sv
module cpu_reg_port_rdpipe #(
    parameter int unsigned LAT    = 2,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_err,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic              out_err,
    output logic [DATA_W-1:0] out_data,
    output logic              busy
);

    generate
        if (LAT == 0) begin : g_bypass
            assign out_vld  = in_vld;
            assign out_err  = in_err;
            assign out_data = in_data;
            assign busy     = 1'b0;
        end else begin : g_pipe
            typedef struct packed {
                logic              vld;
                logic              err;
                logic [DATA_W-1:0] data;
            } stage_t;

            stage_t [LAT-1:0] pipe_d, pipe_q;
            logic             busy_d;

            always_comb begin
                pipe_d[0] = '{vld: in_vld, err: in_err, data: in_data};
                for (int k = 1; k < int'(LAT); k++) pipe_d[k] = pipe_q[k-1];
                busy_d = 1'b0;
                for (int k = 0; k < int'(LAT); k++) busy_d = busy_d | pipe_q[k].vld;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= pipe_d;
            end

            assign out_vld  = pipe_q[LAT-1].vld;
            assign out_err  = pipe_q[LAT-1].err;
            assign out_data = pipe_q[LAT-1].data;
            assign busy     = busy_d;

            // A taken read answers exactly LAT cycles later.
            p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
                in_vld |-> ##LAT out_vld);

            // The stall stays up through the answering cycle.
            p_busy_covers_r6: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld |-> busy);

            // A read just taken raises the stall in the next cycle.
            p_busy_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
                in_vld |=> busy);
        end
    endgenerate

endmodule

// File: rtl/cpu_reg_port.sv
module cpu_reg_port
    import cpu_reg_port_pkg::*;
#(
    parameter int unsigned NUM_REGS = 10,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned RD_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_stall,
    output logic              wr_ack,
    output logic              wr_err,
    output logic              rd_ack,
    output logic              rd_err,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned LAT_USED = (RD_LAT > MAX_RD_LAT) ? MAX_RD_LAT : RD_LAT;

    logic              hit;
    logic              busy;
    logic              wr_take;
    logic              rd_take;
    logic [DATA_W-1:0] bank_rdata;

    always_comb begin
        wr_take = req && req_wr && !busy;
        rd_take = req && !req_wr;
    end

    cpu_reg_port_bank #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_take),
        .addr  (addr),
        .wdata (wdata),
        .hit   (hit),
        .rdata (bank_rdata)
    );

    cpu_reg_port_rdpipe #(
        .LAT    (LAT_USED),
        .DATA_W (DATA_W)
    ) i_rdpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (rd_take),
        .in_err   (!hit),
        .in_data  (bank_rdata),
        .out_vld  (rd_ack),
        .out_err  (rd_err),
        .out_data (rd_data),
        .busy     (busy)
    );

    assign wr_stall = busy;
    assign wr_ack   = wr_take;
    assign wr_err   = wr_take && !hit;

    // Two channels never answer together.
    p_single_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ack && wr_ack));

    // No write completes under the stall.
    p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |-> !wr_ack);

    // A write acknowledge needs a write request in the same cycle.
    p_no_spurious_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (req && req_wr));

    // Unmapped reads come back with the error set and zero data.
    p_unmapped_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rd_err) |-> (rd_data == '0));

endmodule

// File: tb/test_cpu_reg_port.sv
module test_cpu_reg_port;

    localparam int CLK_P    = 10;
    localparam int NREG     = 10;
    localparam int AW       = 4;
    localparam int DW       = 16;
    localparam int RD_LAT   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wr_stall, wr_ack, wr_err, rd_ack, rd_err;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        int            due;
        logic          err;
        logic [DW-1:0] data;
    } pend_t;

    pend_t         pend[$];
    logic [DW-1:0] mdl[NREG];

    always #(CLK_P/2) clk = ~clk;

    cpu_reg_port #(
        .NUM_REGS (NREG),
        .ADDR_W   (AW),
        .DATA_W   (DW),
        .RD_LAT   (RD_LAT)
    ) i_cpu_reg_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .addr     (addr),
        .wdata    (wdata),
        .wr_stall (wr_stall),
        .wr_ack   (wr_ack),
        .wr_err   (wr_err),
        .rd_ack   (rd_ack),
        .rd_err   (rd_err),
        .rd_data  (rd_data)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // One bus cycle: drive, compare against the model, then advance the model.
    task automatic step(input logic r, input logic w, input int a, input logic [DW-1:0] d);
        bit    exp_stall, exp_wack, exp_rack, hit;
        pend_t e;
        @(negedge clk);
        req = r; req_wr = w; addr = AW'(a); wdata = d;
        #1;
        hit       = (a < NREG);
        exp_stall = (pend.size() != 0);
        if (r && !w) begin
            e.due  = cyc + RD_LAT;
            e.err  = !hit;
            e.data = hit ? mdl[a] : '0;
            pend.push_back(e);
        end
        exp_wack = r && w && !exp_stall;
        exp_rack = (pend.size() != 0) && (pend[0].due == cyc);
        chk("R6", "wr_stall", 32'(wr_stall), 32'(exp_stall));
        chk(!r ? "R9" : (exp_stall ? "R7" : "R2"), "wr_ack", 32'(wr_ack), 32'(exp_wack));
        chk("R5", "rd_ack", 32'(rd_ack), 32'(exp_rack));
        chk("R8", "dual_ack", 32'(rd_ack && wr_ack), 32'(0));
        if (exp_wack) chk("R4", "wr_err", 32'(wr_err), 32'(!hit));
        if (exp_rack) begin
            chk("R4", "rd_err", 32'(rd_err), 32'(pend[0].err));
            chk("R3", "rd_data", 32'(rd_data), 32'(pend[0].data));
            void'(pend.pop_front());
        end
        if (exp_wack && hit) mdl[a] = d;
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, '0);
    endtask

    // Keep presenting a write until it is taken (R7 retry behaviour).
    task automatic write_retry(input int a, input logic [DW-1:0] d);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, a, d);
            if (wr_ack) break;
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "wr_ack_rst", 32'(wr_ack), 32'(0));
        chk("R1", "rd_ack_rst", 32'(rd_ack), 32'(0));
        chk("R1", "stall_rst", 32'(wr_stall), 32'(0));
        @(negedge clk);
        rst_n = 1'b1;
        // R1: the bank reads zero after reset
        for (int i = 0; i < NREG; i++) step(1'b1, 1'b0, i, '0);
        idle(4);
        // R2: fill the bank with writes in consecutive cycles
        for (int i = 0; i < NREG; i++) step(1'b1, 1'b1, i, DW'(16'h1100 + i * 16'h0101));
        // R4: unmapped writes on both sides of the map edge
        step(1'b1, 1'b1, NREG, 16'hDEAD);
        step(1'b1, 1'b1, 15, 16'hBEEF);
        // R5, R3: back-to-back reads, then unmapped reads
        for (int i = NREG - 1; i >= 0; i--) step(1'b1, 1'b0, i, '0);
        step(1'b1, 1'b0, NREG, '0);
        step(1'b1, 1'b0, 15, '0);
        idle(4);
        // R6, R7: two writes, two reads, then a write that must wait
        step(1'b1, 1'b1, 2, 16'hA002);
        step(1'b1, 1'b1, 3, 16'hA003);
        step(1'b1, 1'b0, 2, '0);
        step(1'b1, 1'b0, 3, '0);
        write_retry(4, 16'hA004);
        idle(3);
        // R7: a stalled write that is dropped must not land
        step(1'b1, 1'b0, 5, '0);
        step(1'b1, 1'b1, 5, 16'h5555);
        idle(3);
        step(1'b1, 1'b0, 5, '0);
        step(1'b1, 1'b0, 4, '0);
        idle(4);
        // Mixed traffic with pseudo-random operations and addresses
        void'($urandom(32'h1234));
        for (int i = 0; i < 600; i++) begin
            int unsigned rv;
            rv = $urandom;
            step(rv[0] | rv[1], rv[2], int'(rv[7:4]), DW'(rv[31:16]));
        end
        idle(4);
        // R9: quiet bus produces no acknowledges
        idle(6);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=finished", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule